// File: doc/BRIEF.md
# Interpolator Sample and Convert Sequencer

This block times the digital side of a time-interval interpolator. A timing event (a start or stop edge) makes it open the switch that keeps the hold capacitor emptied, wait a short lead time, and then hold a sample strobe high for a fixed number of clock cycles. The same event raises a one-cycle interrupt to the processor. Triggers that arrive while this capture runs are dropped.

A separate path runs the digitization. When the processor asks for a conversion, the block stores a 3-bit source select for an 8-way analog multiplexer and closes a track switch for a settle period. It then opens the switch, sends a one-cycle start to a 12-bit converter, and waits for the converter's done flag. It stores the result, pulses data-valid for one cycle, and clears its busy flag. All times come from parameters in microseconds or nanoseconds, scaled by the clock rate in MHz. The defaults are a 7 us strobe and a 20 us settle.

Top module: `interp_seq`

## Requirements
- R1: After reset, the discharge switch control is 1 (closed). The strobe, interrupt, track switch, converter start, busy and data-valid outputs are 0, and the select and data outputs are all zero.
- R2: An event seen while the capture path is idle makes the discharge control go to 0 and the interrupt go to 1 in the next cycle. The interrupt lasts exactly one cycle.
- R3: The strobe rises exactly LEAD_CYC cycles after the discharge control goes to 0, where LEAD_CYC = max(1, CLK_MHZ*LEAD_NS/1000). The strobe stays high for exactly STROBE_CYC = CLK_MHZ*STROBE_US cycles. The discharge control returns to 1 in the cycle the strobe falls.
- R4: An event seen while the discharge switch is open (during the lead or the strobe) raises no interrupt and does not change the strobe width.
- R5: A conversion request seen while not busy sets busy to 1 in the next cycle. In that same cycle it copies the 3-bit select input to the select output and closes the track switch (1). The track switch stays closed for exactly TRACK_CYC = CLK_MHZ*TRACK_US cycles.
- R6: In the cycle the track switch opens, the converter start is 1, and it lasts exactly one cycle.
- R7: After the start, the block waits for the done input. The cycle after done is seen, the data output holds the converter data, data-valid is 1 for exactly one cycle, and busy is 0.
- R8: A conversion request while busy is ignored. The select output keeps its value and no extra converter start is issued.
- R9: The capture path and the conversion path run independently. An event during a conversion is served as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 1 | Timing event trigger |
| conv_req_i | input | 1 | Processor conversion request |
| src_sel_i | input | MUX_W | Analog source select for the request |
| adc_done_i | input | 1 | Converter completion flag |
| adc_data_i | input | DATA_W | Converter result |
| dump_sw_o | output | 1 | Discharge switch closed |
| strobe_o | output | 1 | Sample strobe |
| irq_o | output | 1 | Event interrupt, one cycle |
| src_sel_o | output | MUX_W | Latched multiplexer select |
| track_sw_o | output | 1 | Track switch closed |
| adc_start_o | output | 1 | Converter start, one cycle |
| busy_o | output | 1 | Conversion in progress |
| data_o | output | DATA_W | Latched conversion result |
| data_valid_o | output | 1 | Result valid, one cycle |

## Verification
The bench builds the block with CLK_MHZ=4 and LEAD_NS=500, which gives a 2-cycle lead, a 28-cycle strobe and an 80-cycle settle. At these sizes every edge of each window can be counted one cycle at a time. The bench also adds a behavioural converter with a 40-cycle latency. With these settings, triggers can be injected during the lead and the strobe, requests can be injected during the settle, and a capture can be run in the middle of a conversion, all within a short run.

// File: rtl/interp_seq.sv
module interp_seq #(
  parameter int CLK_MHZ   = 100,
  parameter int STROBE_US = 7,
  parameter int TRACK_US  = 20,
  parameter int LEAD_NS   = 100,
  parameter int MUX_W     = 3,
  parameter int DATA_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              event_i,
  input  logic              conv_req_i,
  input  logic [MUX_W-1:0]  src_sel_i,
  input  logic              adc_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              dump_sw_o,
  output logic              strobe_o,
  output logic              irq_o,
  output logic [MUX_W-1:0]  src_sel_o,
  output logic              track_sw_o,
  output logic              adc_start_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_valid_o
);
  localparam int STROBE_CYC = CLK_MHZ * STROBE_US;
  localparam int TRACK_CYC  = CLK_MHZ * TRACK_US;
  localparam int LEAD_RAW   = (CLK_MHZ * LEAD_NS) / 1000;
  localparam int LEAD_CYC   = (LEAD_RAW < 1) ? 1 : LEAD_RAW;
  localparam int MAX_A      = (STROBE_CYC > LEAD_CYC) ? STROBE_CYC : LEAD_CYC;
  localparam int MAX_CYC    = (TRACK_CYC > MAX_A) ? TRACK_CYC : MAX_A;
  localparam int CW         = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {CAP_IDLE, CAP_LEAD, CAP_STROBE} cap_t;
  typedef enum logic [1:0] {CV_IDLE, CV_TRACK, CV_START, CV_WAIT} cv_t;

  cap_t          cap_st;
  cv_t           cv_st;
  logic [CW-1:0] cap_cnt, cv_cnt;
  logic          irq_q, dv_q;
  logic [MUX_W-1:0]  sel_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_st  <= CAP_IDLE;
      cap_cnt <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (cap_st)
        CAP_IDLE: if (event_i) begin
          cap_st  <= CAP_LEAD;
          cap_cnt <= CW'(LEAD_CYC - 1);
          irq_q   <= 1'b1;
        end
        CAP_LEAD: if (cap_cnt == '0) begin
          cap_st  <= CAP_STROBE;
          cap_cnt <= CW'(STROBE_CYC - 1);
        end else cap_cnt <= cap_cnt - 1'b1;
        CAP_STROBE: if (cap_cnt == '0) cap_st <= CAP_IDLE;
                    else cap_cnt <= cap_cnt - 1'b1;
        default: cap_st <= CAP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cv_st  <= CV_IDLE;
      cv_cnt <= '0;
      sel_q  <= '0;
      data_q <= '0;
      dv_q   <= 1'b0;
    end else begin
      dv_q <= 1'b0;
      case (cv_st)
        CV_IDLE: if (conv_req_i) begin
          cv_st  <= CV_TRACK;
          cv_cnt <= CW'(TRACK_CYC - 1);
          sel_q  <= src_sel_i;
        end
        CV_TRACK: if (cv_cnt == '0) cv_st <= CV_START;
                  else cv_cnt <= cv_cnt - 1'b1;
        CV_START: cv_st <= CV_WAIT;
        CV_WAIT: if (adc_done_i) begin
          cv_st  <= CV_IDLE;
          data_q <= adc_data_i;
          dv_q   <= 1'b1;
        end
        default: cv_st <= CV_IDLE;
      endcase
    end
  end

  assign dump_sw_o    = (cap_st == CAP_IDLE);
  assign strobe_o     = (cap_st == CAP_STROBE);
  assign irq_o        = irq_q;
  assign src_sel_o    = sel_q;
  assign track_sw_o   = (cv_st == CV_TRACK);
  assign adc_start_o  = (cv_st == CV_START);
  assign busy_o       = (cv_st != CV_IDLE);
  assign data_o       = data_q;
  assign data_valid_o = dv_q;
endmodule

// File: rtl/interp_seq_chk.sv
module interp_seq_chk #(
  parameter int CLK_MHZ   = 100,
  parameter int STROBE_US = 7,
  parameter int MUX_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dump_sw_o,
  input logic             strobe_o,
  input logic             irq_o,
  input logic [MUX_W-1:0] src_sel_o,
  input logic             track_sw_o,
  input logic             adc_start_o,
  input logic             busy_o,
  input logic             data_valid_o
);
  localparam int STROBE_CYC = CLK_MHZ * STROBE_US;
  int strobe_len;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_len <= 0;
    else if (strobe_o) strobe_len <= strobe_len + 1;
    else strobe_len <= 0;
  end

  a_r2_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r2_irq_with_release: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!dump_sw_o && !strobe_o));
  a_r3_open_during_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> !dump_sw_o);
  a_r3_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $past(!dump_sw_o));
  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> (strobe_len == STROBE_CYC));
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);
  a_r6_track_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |-> (!track_sw_o && $past(track_sw_o)));
  a_r7_valid_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> (!busy_o && $past(busy_o)));
  a_r8_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(src_sel_o));
endmodule

bind interp_seq interp_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .STROBE_US(STROBE_US), .MUX_W(MUX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dump_sw_o(dump_sw_o), .strobe_o(strobe_o),
  .irq_o(irq_o), .src_sel_o(src_sel_o), .track_sw_o(track_sw_o),
  .adc_start_o(adc_start_o), .busy_o(busy_o), .data_valid_o(data_valid_o)
);

// File: tb/interp_seq_bench.sv
module interp_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 4, S_US = 7, T_US = 20, L_NS = 500;
  localparam int LEAD = 2, STROBE = MHZ * S_US, TRACK = MHZ * T_US;
  localparam int CONV_LAT = 40;

  logic clk = 0, rst_n = 0;
  logic event_i = 0, conv_req_i = 0, adc_done_i = 0;
  logic [2:0] src_sel_i = 0;
  logic [11:0] adc_data_i = 0;
  logic dump_sw_o, strobe_o, irq_o, track_sw_o, adc_start_o, busy_o, data_valid_o;
  logic [2:0] src_sel_o;
  logic [11:0] data_o;

  int checks = 0, fails = 0, starts = 0, conv_left = 0, cycles = 0;
  logic [11:0] model_data = 0;
  logic [14:0] expq[$];
  bit done_flag = 0;

  interp_seq #(.CLK_MHZ(MHZ), .STROBE_US(S_US), .TRACK_US(T_US), .LEAD_NS(L_NS)) u_interp_seq (
    .clk(clk), .rst_n(rst_n), .event_i(event_i), .conv_req_i(conv_req_i),
    .src_sel_i(src_sel_i), .adc_done_i(adc_done_i), .adc_data_i(adc_data_i),
    .dump_sw_o(dump_sw_o), .strobe_o(strobe_o), .irq_o(irq_o), .src_sel_o(src_sel_o),
    .track_sw_o(track_sw_o), .adc_start_o(adc_start_o), .busy_o(busy_o),
    .data_o(data_o), .data_valid_o(data_valid_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // converter model
  always @(negedge clk) begin
    adc_done_i = 0;
    if (conv_left > 0) begin
      conv_left--;
      if (conv_left == 0) begin adc_done_i = 1; adc_data_i = model_data; end
    end
    if (adc_start_o) begin starts++; conv_left = CONV_LAT; end
  end

  // monitor
  always @(negedge clk) if (rst_n && data_valid_o) begin
    if (expq.size() == 0) chk("R7 unexpected valid", 1, 0);
    else begin
      logic [14:0] e;
      e = expq.pop_front();
      chk("R7 data", int'(data_o), int'(e[11:0]));
      chk("R5 select at result", int'(src_sel_o), int'(e[14:12]));
    end
  end

  task automatic capture(input int inject_at, input string tag);
    int n;
    event_i = 1; @(negedge clk); event_i = 0;
    chk({tag, " irq on event"}, int'(irq_o), 1);
    chk({tag, " discharge released"}, int'(dump_sw_o), 0);
    n = 0;
    while (!strobe_o && n < 100) begin
      if (inject_at == 0 && n == 1) event_i = 1;
      @(negedge clk); n++;
      event_i = 0;
      if (inject_at == 0 && n == 2) chk("R4 no irq in lead", int'(irq_o), 0);
    end
    chk({tag, " lead cycles"}, n, LEAD);
    n = 0;
    while (strobe_o && n < 200) begin
      n++;
      if (inject_at > 0 && n == inject_at) event_i = 1;
      @(negedge clk);
      event_i = 0;
      if (inject_at > 0 && n == inject_at) chk("R4 no irq in strobe", int'(irq_o), 0);
    end
    chk({tag, " strobe width"}, n, STROBE);
    chk({tag, " discharge closed"}, int'(dump_sw_o), 1);
  endtask

  task automatic convert(input logic [2:0] sel, input logic [11:0] d, input bit inj);
    int n, s0;
    s0 = starts;
    model_data = d;
    expq.push_back({sel, d});
    src_sel_i = sel; conv_req_i = 1; @(negedge clk); conv_req_i = 0;
    chk("R5 busy", int'(busy_o), 1);
    chk("R5 select latched", int'(src_sel_o), int'(sel));
    n = 0;
    while (track_sw_o && n < 300) begin
      n++;
      if (inj && n == 5) begin conv_req_i = 1; src_sel_i = ~sel; end
      @(negedge clk);
      if (inj && n == 5) begin
        conv_req_i = 0;
        chk("R8 select kept", int'(src_sel_o), int'(sel));
      end
    end
    chk("R5 track cycles", n, TRACK);
    chk("R6 start with track open", int'(adc_start_o), 1);
    @(negedge clk);
    chk("R6 start single", int'(adc_start_o), 0);
    n = 0;
    while (!data_valid_o && n < 300) begin @(negedge clk); n++; end
    chk("R7 busy cleared", int'(busy_o), 0);
    @(negedge clk);
    chk("R7 valid single", int'(data_valid_o), 0);
    chk(inj ? "R8 one start" : "R6 one start", starts - s0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 discharge", int'(dump_sw_o), 1);
    chk("R1 strobe", int'(strobe_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 track", int'(track_sw_o), 0);
    chk("R1 start", int'(adc_start_o), 0);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 valid", int'(data_valid_o), 0);
    chk("R1 select", int'(src_sel_o), 0);
    chk("R1 data", int'(data_o), 0);
    rst_n = 1;
    @(negedge clk);
    capture(-1, "R2R3");
    @(negedge clk);
    chk("R2 irq single", int'(irq_o), 0);
    repeat (3) @(negedge clk);
    capture(0, "R4 lead");
    repeat (2) @(negedge clk);
    capture(10, "R4 strobe");
    repeat (2) @(negedge clk);
    convert(3'd5, 12'hA3C, 0);
    convert(3'd0, 12'hFFF, 0);
    convert(3'd7, 12'h001, 1);
    fork
      convert(3'd2, 12'h5A5, 0);
      begin repeat (30) @(negedge clk); capture(-1, "R9"); end
    join
    repeat (3) @(negedge clk);
    chk("R7 queue drained", expq.size(), 0);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    while (!done_flag) begin
      @(negedge clk); cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end
endmodule